// File: doc/BRIEF.md
# Serial Prefix Code Decoder

This block turns a serial bitstream into symbol indices for a fixed seven-letter alphabet whose codewords are two to four bits long. It takes at most one bit per clock, qualified by a valid strobe. Each accepted bit moves a small state register one step down a binary decoding tree. When a leaf is reached, the block emits the leaf's 3-bit index with a one-cycle valid pulse and returns to the root in the same step. Because the code is prefix-free, codewords can follow each other with no separators and no idle cycles.

A flush input marks the end of a stream. If the walk is partway through a codeword when flush is asserted, an incomplete flag is raised for that cycle. In every case, flush returns the walk to the root. A synchronous reset also returns the walk to the root.

Top module: `prefix_tree_decoder`

## Requirements
- R1: After a synchronous reset with all inputs low, sym_valid and partial_flag are low, and the next codeword is decoded from the root.
- R2: The codewords, written as the bits are received first to last, and their indices on sym_idx are: 00→0, 010→1, 011→2, 10→3, 110→4, 1110→5, 1111→6. No other index value is ever emitted.
- R3: sym_valid is high only in the cycle whose accepted bit completes a codeword, and sym_idx is valid in that cycle. sym_valid is low on every other accepted bit.
- R4: After a codeword completes, the next accepted bit starts a new codeword from the root. The stream 101100110010110 yields the indices 3, 4, 2, 0, 3, 4.
- R5: A cycle with bit_valid low and flush low leaves the tree position unchanged and emits nothing. Idle cycles inside a codeword therefore do not change the decoded result.
- R6: When flush is high and the walk is not at the root, partial_flag is high in that same cycle. The bit on bit_in in a flush cycle is discarded, sym_valid is low, and the next accepted bit starts from the root.
- R7: When flush is high and the walk is at the root, partial_flag stays low.
- R8: A reset asserted in the middle of a codeword discards the partial codeword, and decoding restarts from the root.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; returns the walk to the root |
| bit_valid | input | 1 | Qualifies bit_in for this cycle |
| bit_in | input | 1 | Next bit of the coded stream |
| flush | input | 1 | End of stream; returns the walk to the root |
| sym_valid | output | 1 | One-cycle pulse when a codeword completes |
| sym_idx | output | 3 | Index of the decoded symbol, 0 to 6 |
| partial_flag | output | 1 | High in a flush cycle that cuts a codeword short |

## Verification
The assertions assume that flush overrides bit_valid, so a bit presented in a flush cycle is never decoded. They also assume that reset is held low once decoding has begun, except where a mid-codeword reset is being tested. The stimulus drives every input on the falling edge and samples outputs before the next rising edge. It sweeps every three-symbol sequence back to back with idle cycles mixed in, and every bit string of up to three bits followed by a flush, some with a bit presented during the flush cycle. Expected symbols come from matching a growing bit buffer against the codeword list, not from walking a tree.

// File: rtl/prefix_tree_decoder.sv
module prefix_tree_decoder #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_valid,
  input  logic             bit_in,
  input  logic             flush,
  output logic             sym_valid,
  output logic [IDX_W-1:0] sym_idx,
  output logic             partial_flag
);

  typedef enum logic [2:0] {
    N_ROOT, N_Z, N_O, N_ZO, N_OO, N_OOO
  } node_t;

  node_t cur, nxt;
  logic leaf;
  logic [IDX_W-1:0] idx;

  always_comb begin
    nxt  = cur;
    leaf = 1'b0;
    idx  = '0;
    if (flush) begin
      nxt = N_ROOT;
    end else if (bit_valid) begin
      case (cur)
        N_ROOT: nxt = bit_in ? N_O : N_Z;
        N_Z: begin
          if (bit_in) nxt = N_ZO;
          else begin leaf = 1'b1; idx = IDX_W'(0); nxt = N_ROOT; end
        end
        N_ZO: begin
          leaf = 1'b1; idx = bit_in ? IDX_W'(2) : IDX_W'(1); nxt = N_ROOT;
        end
        N_O: begin
          if (bit_in) nxt = N_OO;
          else begin leaf = 1'b1; idx = IDX_W'(3); nxt = N_ROOT; end
        end
        N_OO: begin
          if (bit_in) nxt = N_OOO;
          else begin leaf = 1'b1; idx = IDX_W'(4); nxt = N_ROOT; end
        end
        N_OOO: begin
          leaf = 1'b1; idx = bit_in ? IDX_W'(6) : IDX_W'(5); nxt = N_ROOT;
        end
        default: nxt = N_ROOT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cur <= N_ROOT;
    else     cur <= nxt;
  end

  assign sym_valid    = leaf;
  assign sym_idx      = idx;
  assign partial_flag = flush && (cur != N_ROOT);

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst) sym_valid |-> (sym_idx <= IDX_W'(6))); // R2
  AST_ROOT_NO_EMIT: assert property (@(posedge clk) disable iff (rst) (cur == N_ROOT) |-> !sym_valid); // R3
  AST_LEAF_TO_ROOT: assert property (@(posedge clk) disable iff (rst) sym_valid |=> (cur == N_ROOT)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) (!bit_valid && !flush) |=> $stable(cur)); // R5
  AST_FLUSH_NO_EMIT: assert property (@(posedge clk) disable iff (rst) flush |-> !sym_valid); // R6
  AST_FLUSH_TO_ROOT: assert property (@(posedge clk) disable iff (rst) flush |=> (cur == N_ROOT)); // R6
  AST_RESET_ROOT: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (cur == N_ROOT)); // R8

endmodule

// File: tb/prefix_tree_decoder_tb_top.sv
module prefix_tree_decoder_tb_top;
  logic clk = 1'b0;
  logic rst, bit_valid, bit_in, flush;
  logic sym_valid, partial_flag;
  logic [2:0] sym_idx;
  int total = 0, bad = 0;
  int mlen = 0;
  int mval = 0;
  int got_n = 0;
  int got [0:15];
  int cw_len [0:6] = '{2, 3, 3, 2, 3, 4, 4};
  int cw_val [0:6] = '{0, 2, 3, 2, 6, 14, 15};

  always #10 clk = ~clk;

  prefix_tree_decoder dut_i (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in), .flush(flush),
    .sym_valid(sym_valid), .sym_idx(sym_idx), .partial_flag(partial_flag)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic v, input logic b, input logic f, input string tag);
    int esv = 0, eidx = 0, eflag = 0, nlen, nval;
    @(negedge clk);
    bit_valid = v; bit_in = b; flush = f;
    #5;
    if (f) begin
      eflag = (mlen != 0);
      mlen = 0; mval = 0;
    end else if (v) begin
      nlen = mlen + 1;
      nval = mval * 2 + int'(b);
      mlen = nlen; mval = nval;
      for (int k = 0; k < 7; k++)
        if (cw_len[k] == nlen && cw_val[k] == nval) begin
          esv = 1; eidx = k; mlen = 0; mval = 0;
        end
    end
    check({tag, " sym_valid"}, int'(sym_valid), esv);
    check({tag, " partial_flag"}, int'(partial_flag), eflag);
    if (esv == 1) begin
      check({tag, " sym_idx"}, int'(sym_idx), eidx);
      if (got_n < 16) got[got_n] = int'(sym_idx);
      got_n++;
    end
  endtask

  task automatic send_sym(input int s, inout int gap, input string tag);
    for (int i = cw_len[s] - 1; i >= 0; i--) begin
      step(1'b1, 1'(cw_val[s] >> i), 1'b0, tag);
      gap++;
      if (gap % 5 == 0) step(1'b0, 1'(gap >> 1), 1'b0, "R5 idle");
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bit_valid = 1'b0; bit_in = 1'b0; flush = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    mlen = 0; mval = 0;
  endtask

  initial begin
    #4000000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int gap;
    string stream;
    int exp_seq [0:5];
    rst = 1'b1; bit_valid = 1'b0; bit_in = 1'b0; flush = 1'b0;
    repeat (2) @(negedge clk);
    #5;
    check("R1 sym_valid in reset", int'(sym_valid), 0);
    check("R1 partial_flag in reset", int'(partial_flag), 0);
    do_reset();
    step(1'b0, 1'b0, 1'b1, "R1 R7 flush at root");
    step(1'b1, 1'b0, 1'b0, "R1");
    step(1'b1, 1'b0, 1'b0, "R1");

    stream = "101100110010110";
    exp_seq = '{3, 4, 2, 0, 3, 4};
    got_n = 0;
    for (int i = 0; i < stream.len(); i++)
      step(1'b1, stream[i] == "1", 1'b0, "R4 stream");
    check("R4 symbol count", got_n, 6);
    for (int i = 0; i < 6; i++) check("R4 symbol order", got[i], exp_seq[i]);

    gap = 0;
    for (int a = 0; a < 7; a++)
      for (int b = 0; b < 7; b++)
        for (int c = 0; c < 7; c++) begin
          got_n = 0;
          send_sym(a, gap, "R2 R3 seq");
          send_sym(b, gap, "R2 R3 seq");
          send_sym(c, gap, "R2 R3 seq");
          check("R4 back-to-back count", got_n, 3);
          check("R2 first", got[0], a);
          check("R2 third", got[2], c);
        end

    for (int len = 0; len <= 3; len++)
      for (int v = 0; v < (1 << len); v++)
        for (int fb = 0; fb < 2; fb++) begin
          for (int i = len - 1; i >= 0; i--) step(1'b1, 1'((v >> i) & 1), 1'b0, "R6 prefix");
          step(1'(fb), 1'b1, 1'b1, "R6 R7 flush");
          got_n = 0;
          step(1'b1, 1'b0, 1'b0, "R6 after flush");
          step(1'b1, 1'b1, 1'b0, "R6 after flush");
          step(1'b1, 1'b0, 1'b0, "R6 after flush");
          check("R6 restart from root", got_n == 1 ? got[0] : -1, 1);
        end

    step(1'b1, 1'b1, 1'b0, "R8 partial");
    step(1'b1, 1'b1, 1'b0, "R8 partial");
    step(1'b1, 1'b1, 1'b0, "R8 partial");
    do_reset();
    got_n = 0;
    step(1'b1, 1'b0, 1'b0, "R8 after reset");
    step(1'b1, 1'b0, 1'b0, "R8 after reset");
    check("R8 restart from root", got_n == 1 ? got[0] : -1, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule